// File: doc/BRIEF.md
# Descriptor-Driven DMA Command Sequencer

This block walks a chain of 16-byte command descriptors held in memory. It reads each one through a simple request/acknowledge memory port. It then carries out the command it holds: an outbound or inbound data transfer, a quad store or load, a no-op, or a stop. Transfers are handed to an external data mover through a request/acknowledge handshake that carries a byte count. The mover reports back how many bytes it actually moved.

Each descriptor also holds three 2-bit codes, for interrupt, branch and wait. Each code is resolved against its own condition input from the status block. The condition inputs arrive already matched, as (status & mask) == value. When a command finishes, the sequencer writes two values into the descriptor's last word: the 16-bit channel status and the residual byte count. It then follows either the next sequential descriptor or the branch target. Software starts a chain with a start pulse and an address. A stop descriptor parks the sequencer, and a wake pulse resumes it at that descriptor.

Top module: `dma_cmd_seq`

## Requirements
- R1: After reset the sequencer is idle: desc_req, xfer_req and irq are 0, and chan_status shows run and active cleared.
- R2: A start pulse loads start_addr as the command pointer. The sequencer then reads the words at pointer+0, +4 and +8. Each request stays asserted with a stable address until desc_ack.
- R3: Word 0 holds the request count in [15:0], the command in [19:16], the interrupt code in [21:20], the branch code in [23:22] and the wait code in [25:24]. Word 1 holds the data address and word 2 the branch target. Commands 0 to 5 (output-more, output-last, input-more, input-last, store-quad, load-quad) raise xfer_req with xfer_cmd equal to the command, xfer_addr equal to word 1 and xfer_count equal to the request count. The request stays stable until xfer_ack.
- R4: On completion the sequencer writes word 3 at pointer+12. The channel status goes in bits [15:0] and the residual in bits [31:16]. The residual is the request count minus xfer_done, or 0 when more bytes than requested were moved.
- R5: When no branch is taken, the next descriptor is fetched at pointer+16.
- R6: Branch code 0 never branches, 1 branches when cond_branch is 1, 2 branches when cond_branch is 0, and 3 always branches. A taken branch fetches next from the branch target. It also sets status bit 8 in the written-back word and in chan_status until the next write-back.
- R7: The interrupt code uses the same 0..3 encoding against cond_int. When it fires, irq is high for exactly one cycle, in the cycle after the write-back is acknowledged.
- R8: The wait code uses the same 0..3 encoding against cond_wait. While the wait applies, the sequencer holds after the command's transfer and issues no write-back.
- R9: A no-op (command 6) issues no transfer. It writes back a residual equal to its request count, and its interrupt and branch codes are still honoured.
- R10: A stop (command 7, and likewise codes 8 to 15) issues no transfer and no write-back. It clears active and keeps the pointer at the stop descriptor. A wake pulse while run is set then refetches from that same address.
- R11: A stop pulse clears run. The command in progress still completes its write-back, but no further descriptor is fetched, and wake is ignored while run is clear.
- R12: chan_status holds run in bit 15, active in bit 10 and branch-taken in bit 8. Bits [7:0] reflect dev_status, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain at start_addr |
| start_addr | input | AW | Address of the first descriptor (16-byte aligned) |
| stop | input | 1 | Clear run; halt after the current command |
| wake | input | 1 | Resume a chain parked on a stop descriptor |
| dev_status | input | 8 | Device-dependent status bits for the low status byte |
| cond_int | input | 1 | Matched condition for the interrupt code |
| cond_branch | input | 1 | Matched condition for the branch code |
| cond_wait | input | 1 | Matched condition for the wait code |
| desc_req | output | 1 | Descriptor memory access request |
| desc_we | output | 1 | Access is a write (write-back) |
| desc_addr | output | AW | Descriptor memory byte address |
| desc_wdata | output | 32 | Write-back data |
| desc_rdata | input | 32 | Read data, valid with desc_ack |
| desc_ack | input | 1 | Access complete |
| xfer_req | output | 1 | Transfer request to the data mover |
| xfer_cmd | output | 3 | Transfer command code |
| xfer_addr | output | AW | Transfer data address |
| xfer_count | output | CW | Requested byte count |
| xfer_ack | input | 1 | Transfer complete |
| xfer_done | input | CW | Bytes actually moved, valid with xfer_ack |
| irq | output | 1 | One-cycle interrupt pulse |
| chan_status | output | 16 | Live channel status |

## Verification
The assertions take several properties of the environment for granted. Descriptor addresses and branch targets are 16-byte aligned. The memory and the data mover acknowledge only requests that are pending, and each acknowledge lasts a single cycle. The condition inputs stay stable while a command is held or being written back. The bench keeps within these limits in three ways. It places every descriptor and target on a 16-byte boundary. Its models of the memory and the mover answer each request exactly once, one cycle after it appears. It changes cond_* and dev_status only while the sequencer is idle, or, for the wait release, while the sequencer is held in its wait.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_XFER,
        S_HOLD,
        S_WB
    } seq_state_e;

    localparam logic [3:0] OP_NOP  = 4'd6;
    localparam logic [3:0] OP_STOP = 4'd7;
    localparam logic [3:0] OP_LAST_XFER = 4'd5;

    localparam int unsigned DESC_BYTES = 16;
    localparam int unsigned WB_OFFSET  = 12;

endpackage

// File: rtl/dma_cond_eval.sv
module dma_cond_eval (
    input  logic [1:0] code,
    input  logic       cond,
    output logic       take
);
    // 0 never, 1 on cond true, 2 on cond false, 3 always
    always_comb begin
        unique case (code)
            2'd0:    take = 1'b0;
            2'd1:    take = cond;
            2'd2:    take = ~cond;
            default: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/dma_residual.sv
module dma_residual #(
    parameter int unsigned CW = 16
) (
    input  logic [CW-1:0] requested,
    input  logic [CW-1:0] moved,
    output logic [CW-1:0] residual
);
    always_comb begin
        if (moved >= requested) residual = '0;
        else                    residual = requested - moved;
    end
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          stop,
    input  logic          wake,
    input  logic [7:0]    dev_status,
    input  logic          cond_int,
    input  logic          cond_branch,
    input  logic          cond_wait,
    output logic          desc_req,
    output logic          desc_we,
    output logic [AW-1:0] desc_addr,
    output logic [31:0]   desc_wdata,
    input  logic [31:0]   desc_rdata,
    input  logic          desc_ack,
    output logic          xfer_req,
    output logic [2:0]    xfer_cmd,
    output logic [AW-1:0] xfer_addr,
    output logic [CW-1:0] xfer_count,
    input  logic          xfer_ack,
    input  logic [CW-1:0] xfer_done,
    output logic          irq,
    output logic [15:0]   chan_status
);
    localparam int unsigned NCOND = 3;
    localparam int unsigned STAT_W = 16;
    localparam int unsigned IDX_W = 2;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(2);

    typedef struct packed {
        seq_state_e      state;
        logic [IDX_W-1:0] idx;
        logic [AW-1:0]   ptr;
        logic [CW-1:0]   req_cnt;
        logic [3:0]      cmd;
        logic [1:0]      int_code;
        logic [1:0]      br_code;
        logic [1:0]      wt_code;
        logic [AW-1:0]   data_addr;
        logic [AW-1:0]   br_target;
        logic [CW-1:0]   done_cnt;
        logic            run;
        logic            active;
        logic            br_bit;
        logic            irq;
    } seq_regs_t;

    seq_regs_t q, d;

    // condition decisions: 0 interrupt, 1 branch, 2 wait
    logic [NCOND-1:0] cond_vec;
    logic [NCOND-1:0] take_vec;
    logic [1:0]       code_vec [NCOND];
    logic             int_take, br_take, wt_take;
    logic [CW-1:0]    residual;
    logic [STAT_W-1:0] wb_status;

    assign cond_vec    = {cond_wait, cond_branch, cond_int};
    assign code_vec[0] = q.int_code;
    assign code_vec[1] = q.br_code;
    assign code_vec[2] = q.wt_code;

    for (genvar g = 0; g < NCOND; g++) begin : g_cond
        dma_cond_eval u_eval (
            .code (code_vec[g]),
            .cond (cond_vec[g]),
            .take (take_vec[g])
        );
    end

    assign int_take = take_vec[0];
    assign br_take  = take_vec[1];
    assign wt_take  = take_vec[2];

    dma_residual #(.CW(CW)) u_resid (
        .requested (q.req_cnt),
        .moved     (q.done_cnt),
        .residual  (residual)
    );

    assign wb_status = {q.run, 4'b0000, q.active, 1'b0, br_take, dev_status};

    always_comb begin
        d     = q;
        d.irq = 1'b0;
        if (stop) d.run = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start) begin
                    d.ptr    = start_addr;
                    d.run    = 1'b1;
                    d.active = 1'b1;
                    d.idx    = '0;
                    d.state  = S_FETCH;
                end else if (wake && q.run && !q.active) begin
                    d.active = 1'b1;
                    d.idx    = '0;
                    d.state  = S_FETCH;
                end
            end
            S_FETCH: begin
                if (desc_ack) begin
                    unique case (q.idx)
                        2'd0: begin
                            d.req_cnt  = desc_rdata[CW-1:0];
                            d.cmd      = desc_rdata[19:16];
                            d.int_code = desc_rdata[21:20];
                            d.br_code  = desc_rdata[23:22];
                            d.wt_code  = desc_rdata[25:24];
                        end
                        2'd1:    d.data_addr = desc_rdata[AW-1:0];
                        default: d.br_target = desc_rdata[AW-1:0];
                    endcase
                    d.idx = q.idx + 1'b1;
                    if (q.idx == LAST_IDX) begin
                        if (q.cmd <= OP_LAST_XFER) begin
                            d.state = S_XFER;
                        end else if (q.cmd == OP_NOP) begin
                            d.done_cnt = '0;
                            d.state    = S_HOLD;
                        end else begin
                            d.active = 1'b0;
                            d.state  = S_IDLE;
                        end
                    end
                end
            end
            S_XFER: begin
                if (xfer_ack) begin
                    d.done_cnt = xfer_done;
                    d.state    = S_HOLD;
                end
            end
            S_HOLD: begin
                if (!wt_take) d.state = S_WB;
            end
            S_WB: begin
                if (desc_ack) begin
                    d.br_bit = br_take;
                    d.irq    = int_take;
                    d.ptr    = br_take ? q.br_target : q.ptr + AW'(DESC_BYTES);
                    d.idx    = '0;
                    d.active = d.run;
                    d.state  = d.run ? S_FETCH : S_IDLE;
                end
            end
            default: d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign desc_req    = (q.state == S_FETCH) || (q.state == S_WB);
    assign desc_we     = (q.state == S_WB);
    assign desc_addr   = (q.state == S_WB) ? q.ptr + AW'(WB_OFFSET)
                                           : q.ptr + AW'({q.idx, 2'b00});
    assign desc_wdata  = {residual, wb_status};
    assign xfer_req    = (q.state == S_XFER);
    assign xfer_cmd    = q.cmd[2:0];
    assign xfer_addr   = q.data_addr;
    assign xfer_count  = q.req_cnt;
    assign irq         = q.irq;
    assign chan_status = {q.run, 4'b0000, q.active, 1'b0, q.br_bit, dev_status};

    // ---------------- assertions ----------------
    assert_ports_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_req && xfer_req));

    assert_desc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req && !desc_ack |=> desc_req && $stable(desc_addr) && $stable(desc_we));

    assert_xfer_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_count) && $stable(xfer_addr));

    assert_irq_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(desc_req && desc_we && desc_ack));

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_wait_blocks_wb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == S_HOLD && wt_take) |=> !desc_req);

    assert_inactive_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_status[10] |-> !desc_req && !xfer_req);

    assert_wb_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_req && desc_we |-> desc_addr[3:0] == 4'hC);

endmodule

// File: tb/tb_dma_cmd_seq.sv
module tb_dma_cmd_seq;
    localparam int unsigned AW = 32;
    localparam int unsigned CW = 16;
    localparam logic [7:0] DEV = 8'h5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          stop = 1'b0;
    logic          wake = 1'b0;
    logic [7:0]    dev_status = DEV;
    logic          cond_int = 1'b0;
    logic          cond_branch = 1'b0;
    logic          cond_wait = 1'b0;
    logic          desc_req, desc_we;
    logic [AW-1:0] desc_addr;
    logic [31:0]   desc_wdata;
    logic [31:0]   desc_rdata;
    logic          desc_ack;
    logic          xfer_req;
    logic [2:0]    xfer_cmd;
    logic [AW-1:0] xfer_addr;
    logic [CW-1:0] xfer_count;
    logic          xfer_ack;
    logic [CW-1:0] xfer_done;
    logic          irq;
    logic [15:0]   chan_status;

    always #2 clk = ~clk;

    dma_cmd_seq #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .stop(stop), .wake(wake), .dev_status(dev_status),
        .cond_int(cond_int), .cond_branch(cond_branch), .cond_wait(cond_wait),
        .desc_req(desc_req), .desc_we(desc_we), .desc_addr(desc_addr),
        .desc_wdata(desc_wdata), .desc_rdata(desc_rdata), .desc_ack(desc_ack),
        .xfer_req(xfer_req), .xfer_cmd(xfer_cmd), .xfer_addr(xfer_addr),
        .xfer_count(xfer_count), .xfer_ack(xfer_ack), .xfer_done(xfer_done),
        .irq(irq), .chan_status(chan_status)
    );

    // memory and mover models, with logs
    logic [31:0] mem [0:63];
    logic        h_we = 1'b0;
    logic [5:0]  h_idx = '0;
    logic [31:0] h_data = '0;
    logic [CW-1:0] tb_done = '0;
    int fetch_cnt = 0, wr_cnt = 0, x_cnt = 0, irq_cnt = 0;
    logic [AW-1:0] last_fetch = '0, last_wr_addr = '0, x_addr = '0;
    logic [31:0]   last_wr_data = '0;
    logic [2:0]    x_cmd = '0;
    logic [CW-1:0] x_count = '0;

    always @(posedge clk) begin
        if (h_we) mem[h_idx] <= h_data;
        if (irq) irq_cnt <= irq_cnt + 1;
        if (!rst_n) begin
            desc_ack <= 1'b0;
            desc_rdata <= '0;
        end else if (desc_req && !desc_ack) begin
            desc_ack <= 1'b1;
            if (desc_we) begin
                mem[desc_addr[7:2]] <= desc_wdata;
                wr_cnt <= wr_cnt + 1;
                last_wr_addr <= desc_addr;
                last_wr_data <= desc_wdata;
            end else begin
                desc_rdata <= mem[desc_addr[7:2]];
                fetch_cnt <= fetch_cnt + 1;
                last_fetch <= desc_addr;
            end
        end else begin
            desc_ack <= 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            xfer_ack <= 1'b0;
            xfer_done <= '0;
        end else if (xfer_req && !xfer_ack) begin
            xfer_ack <= 1'b1;
            xfer_done <= tb_done;
            x_cnt <= x_cnt + 1;
            x_cmd <= xfer_cmd;
            x_addr <= xfer_addr;
            x_count <= xfer_count;
        end else begin
            xfer_ack <= 1'b0;
        end
    end

    int n_chk = 0, n_fail = 0;
    int f0, w0, x0, i0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put_word(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        h_we = 1'b1; h_idx = addr[7:2]; h_data = data;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic put_desc(input logic [7:0] a, input logic [3:0] cmd, input logic [15:0] req,
                            input logic [1:0] ic, input logic [1:0] bc, input logic [1:0] wc,
                            input logic [31:0] daddr, input logic [31:0] tgt);
        put_word(a,      {6'b0, wc, bc, ic, cmd, req});
        put_word(a + 4,  daddr);
        put_word(a + 8,  tgt);
        put_word(a + 12, 32'h0);
    endtask

    task automatic snap();
        f0 = fetch_cnt; w0 = wr_cnt; x0 = x_cnt; i0 = irq_cnt;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (chan_status[10] && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) chk("timeout waiting for idle", 32'd1, 32'd0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_from(input logic [7:0] a);
        snap();
        @(negedge clk);
        start = 1'b1; start_addr = {24'h0, a};
        @(negedge clk);
        start = 1'b0;
        wait_idle();
    endtask

    task automatic t_reset();
        chk("R1 desc_req", {31'b0, desc_req}, 32'd0);
        chk("R1 xfer_req", {31'b0, xfer_req}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1/R12 chan_status", {16'b0, chan_status}, {16'b0, 8'h00, DEV});
    endtask

    task automatic t_output();
        put_desc(8'h00, 4'd1, 16'd100, 2'd0, 2'd0, 2'd0, 32'h1000, 32'h0);
        put_desc(8'h10, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        tb_done = 16'd100;
        run_from(8'h00);
        chk("R3 xfer count", 32'(x_cnt - x0), 32'd1);
        chk("R3 xfer_cmd", {29'b0, x_cmd}, 32'd1);
        chk("R3 xfer_addr", x_addr, 32'h1000);
        chk("R3 xfer_count", {16'b0, x_count}, 32'd100);
        chk("R4 write count", 32'(wr_cnt - w0), 32'd1);
        chk("R4 write addr", last_wr_addr, 32'h0C);
        chk("R4/R12 write data", last_wr_data, {16'd0, 16'h8400 | {8'h00, DEV}});
        chk("R2/R5 fetch count", 32'(fetch_cnt - f0), 32'd6);
        chk("R5 last fetch", last_fetch, 32'h18);
        chk("R10/R12 parked status", {16'b0, chan_status}, {16'b0, 16'h8000 | {8'h00, DEV}});
    endtask

    task automatic t_residual();
        put_desc(8'h20, 4'd3, 16'd200, 2'd0, 2'd0, 2'd0, 32'h2000, 32'h0);
        put_desc(8'h30, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        tb_done = 16'd150;
        run_from(8'h20);
        chk("R3 input cmd", {29'b0, x_cmd}, 32'd3);
        chk("R4 residual 50", {16'b0, last_wr_data[31:16]}, 32'd50);
        put_desc(8'h20, 4'd4, 16'd10, 2'd0, 2'd0, 2'd0, 32'h2400, 32'h0);
        tb_done = 16'd150;
        run_from(8'h20);
        chk("R3 store-quad cmd", {29'b0, x_cmd}, 32'd4);
        chk("R4 residual saturates", {16'b0, last_wr_data[31:16]}, 32'd0);
    endtask

    task automatic t_nop_branch();
        put_desc(8'h40, 4'd6, 16'd8, 2'd0, 2'd3, 2'd0, 32'h0, 32'h80);
        put_desc(8'h50, 4'd1, 16'd4, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        put_desc(8'h80, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        run_from(8'h40);
        chk("R9 nop no transfer", 32'(x_cnt - x0), 32'd0);
        chk("R9 nop residual", {16'b0, last_wr_data[31:16]}, 32'd8);
        chk("R6 branch bit written", {16'b0, last_wr_data[15:0]}, {16'b0, 16'h8500 | {8'h00, DEV}});
        chk("R6 fetched target", last_fetch, 32'h88);
        chk("R6/R12 branch bit live", {16'b0, chan_status}, {16'b0, 16'h8100 | {8'h00, DEV}});
    endtask

    task automatic t_branch_codes();
        // code 1, cond 0: not taken
        put_desc(8'h40, 4'd6, 16'd0, 2'd0, 2'd1, 2'd0, 32'h0, 32'h80);
        put_desc(8'h50, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        cond_branch = 1'b0;
        run_from(8'h40);
        chk("R6 code1 cond0 sequential", last_fetch, 32'h58);
        chk("R6 code1 bit clear", {31'b0, last_wr_data[8]}, 32'd0);
        // code 1, cond 1: taken
        cond_branch = 1'b1;
        run_from(8'h40);
        chk("R6 code1 cond1 taken", last_fetch, 32'h88);
        // code 2, cond 0: taken
        put_desc(8'h40, 4'd6, 16'd0, 2'd0, 2'd2, 2'd0, 32'h0, 32'h80);
        cond_branch = 1'b0;
        run_from(8'h40);
        chk("R6 code2 cond0 taken", last_fetch, 32'h88);
        // code 0, cond 1: never
        put_desc(8'h40, 4'd6, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h80);
        cond_branch = 1'b1;
        run_from(8'h40);
        chk("R6 code0 never", last_fetch, 32'h58);
        cond_branch = 1'b0;
    endtask

    task automatic t_irq();
        put_desc(8'h50, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        cond_int = 1'b1;
        put_desc(8'h40, 4'd6, 16'd0, 2'd1, 2'd0, 2'd0, 32'h0, 32'h0);
        run_from(8'h40);
        chk("R7 code1 cond1 fires", 32'(irq_cnt - i0), 32'd1);
        put_desc(8'h40, 4'd6, 16'd0, 2'd2, 2'd0, 2'd0, 32'h0, 32'h0);
        run_from(8'h40);
        chk("R7 code2 cond1 silent", 32'(irq_cnt - i0), 32'd0);
        put_desc(8'h40, 4'd6, 16'd0, 2'd3, 2'd0, 2'd0, 32'h0, 32'h0);
        cond_int = 1'b0;
        run_from(8'h40);
        chk("R7 code3 always", 32'(irq_cnt - i0), 32'd1);
        put_desc(8'h40, 4'd6, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        cond_int = 1'b1;
        run_from(8'h40);
        chk("R7 code0 never", 32'(irq_cnt - i0), 32'd0);
        cond_int = 1'b0;
    endtask

    task automatic t_wait();
        put_desc(8'h40, 4'd0, 16'd12, 2'd0, 2'd0, 2'd1, 32'h3000, 32'h0);
        put_desc(8'h50, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        cond_wait = 1'b1;
        tb_done = 16'd12;
        snap();
        @(negedge clk);
        start = 1'b1; start_addr = 32'h40;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        chk("R8 transfer done before hold", 32'(x_cnt - x0), 32'd1);
        chk("R8 no write-back while held", 32'(wr_cnt - w0), 32'd0);
        chk("R8 still active", {31'b0, chan_status[10]}, 32'd1);
        cond_wait = 1'b0;
        wait_idle();
        chk("R8 write-back after release", 32'(wr_cnt - w0), 32'd1);
    endtask

    task automatic t_stop_wake();
        put_desc(8'h90, 4'd6, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        put_desc(8'hA0, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        run_from(8'h90);
        chk("R10 stop no write-back", 32'(wr_cnt - w0), 32'd1);
        chk("R10 stop fetched", last_fetch, 32'hA8);
        put_desc(8'hA0, 4'd6, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        put_desc(8'hB0, 4'd7, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        snap();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        wait_idle();
        chk("R10 wake fetch count", 32'(fetch_cnt - f0), 32'd6);
        chk("R10 wake resumed at stop slot", last_wr_addr, 32'hAC);
    endtask

    task automatic t_stop_input();
        put_desc(8'hC0, 4'd6, 16'd0, 2'd0, 2'd0, 2'd1, 32'h0, 32'h0);
        put_desc(8'hD0, 4'd6, 16'd0, 2'd0, 2'd0, 2'd0, 32'h0, 32'h0);
        cond_wait = 1'b1;
        snap();
        @(negedge clk);
        start = 1'b1; start_addr = 32'hC0;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        cond_wait = 1'b0;
        wait_idle();
        chk("R11 current write-back done", last_wr_addr, 32'hCC);
        chk("R11/R12 written status run clear", {16'b0, last_wr_data[15:0]}, {16'b0, 16'h0400 | {8'h00, DEV}});
        chk("R11 no further fetch", 32'(fetch_cnt - f0), 32'd3);
        chk("R11 halted status", {16'b0, chan_status}, {16'b0, 8'h00, DEV});
        snap();
        @(negedge clk);
        wake = 1'b1;
        @(negedge clk);
        wake = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11 wake ignored", 32'(fetch_cnt - f0), 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_output();
        t_residual();
        t_nop_branch();
        t_branch_codes();
        t_irq();
        t_wait();
        t_stop_wake();
        t_stop_input();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule